// File: doc/BRIEF.md
# Two-Lane Accumulator Interpolator

This block is a register-mapped arithmetic helper with two 32-bit accumulators and three base registers. Each lane takes an accumulator, shifts it right, keeps a chosen bit field, can sign-extend that field and adds a base value. Software reads a lane result or a combined result in one of two ways. A peek read has no side effects. A pop read also writes the lane results back into the accumulators, so repeated pops walk an address or phase sequence without extra instructions.

A per-instance parameter adds one optional mode. Instance kind 1 has a blend mode, which interpolates linearly between two bases. Instance kind 2 has a clamp mode, which limits lane 0 to a range. The bus is a simple single-cycle port: a write or a read is applied each cycle, and read data is combinational on the same cycle as the read strobe. When both strobes are high, the write wins and the read is dropped, so no pop happens.

Word addresses (busAddr): 0 lane-0 control, 1 lane-1 control, 2 accumulator 0, 3 accumulator 1, 4 base 0, 5 base 1, 6 base 2, 7 base pair (write-only, reads 0), 8 add-to-accumulator 0, 9 add-to-accumulator 1, 10 peek lane 0, 11 peek lane 1, 12 peek full, 13 pop lane 0, 14 pop lane 1, 15 pop full.

Top module: `interp_unit`

## Requirements
- R1: After reset every accumulator, base and control register is zero, and every address reads 0.
- R2: A lane value is the lane input logically shifted right by control bits 4:0, then ANDed with a field mask covering bit positions from control bits 9:5 (low) up to control bits 14:10 (high), both ends included. If the high bound is below the low bound, the mask and the lane value are zero.
- R3: With control bit 15 set, the lane value is sign-extended from the high mask bound to 32 bits.
- R4: A lane result is the lane value plus that lane's base. With control bit 18 set, the unshifted lane input replaces the lane value in the lane result only. The full result is always base 2 plus both lane values.
- R5: With control bit 16 set, a lane takes the other lane's accumulator as its input. This also feeds the bit-18 bypass.
- R6: A peek read changes no register. A pop read returns the selected result and, on the next clock, loads each accumulator with its own lane result, or with the other lane's result when that lane's control bit 17 is set.
- R7: Control bits 20:19 are ORed into bits 29:28 of lane-result reads (peek and pop) only. Values written back by a pop carry no forced bits.
- R8: A write to an add address adds the write data to that accumulator. A read from it returns the lane value without the base.
- R9: A base-pair write loads bits 15:0 into base 0 and bits 31:16 into base 1. Each half is sign-extended when its lane's bit 15 is set, and zero-extended otherwise.
- R10: In a blend instance with lane-0 control bit 21 set, lane 1's result is floor((base0*(256-f) + base1*f)/256), with f the low 8 bits of lane 1's value. The bases are signed when lane-1 bit 15 is set. Lane 0's result omits base 0, and the full result is base 2 plus lane 0's value.
- R11: In a clamp instance with lane-0 control bit 22 set, lane 0's result is its value (or raw input under bit 18), with no base added. Below base 0 it returns base 0; otherwise, above base 1 it returns base 1. Comparisons are signed when lane-0 bit 15 is set.
- R12: Lane-0 control reads return bit 23 set when the lane-0 shifted input has a set bit above its high mask bound, bit 24 likewise for lane 1, and bit 25 as their OR.
- R13: Bit 21 is stored only in a blend instance and bit 22 only in a clamp instance, both only in lane-0 control. Elsewhere they, and control bits above 22, read as 0.
- R14: Control, accumulator and base registers read back what was written. When write and read strobes coincide, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe (pop side effect on pop addresses) |
| busAddr | input | 4 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of busRdEn, 0 otherwise |

## Verification
Read data is combinational, so every result is due in the same cycle as the read strobe. Register writes, add writes and pop write-backs are visible to a read issued in the next cycle. The bench drives one operation per cycle at the falling edge. It samples busRdata 2 ns later, before the rising edge that commits any pop, and updates its own model after each comparison. Both parameter variants are instantiated and driven with the same style of directed and seeded random traffic.

// File: rtl/interp_pkg.sv
package interp_pkg;

  localparam int MODE_NONE  = 0;
  localparam int MODE_BLEND = 1;
  localparam int MODE_CLAMP = 2;

  // control field positions
  localparam int SH_LO     = 0;
  localparam int LSB_LO    = 5;
  localparam int MSB_LO    = 10;
  localparam int BIT_SGN   = 15;
  localparam int BIT_XIN   = 16;
  localparam int BIT_XRES  = 17;
  localparam int BIT_RAW   = 18;
  localparam int FRC_LO    = 19;
  localparam int BIT_BLEND = 21;
  localparam int BIT_CLAMP = 22;
  localparam int BIT_OVF0  = 23;
  localparam int BIT_OVF1  = 24;
  localparam int BIT_OVFA  = 25;
  localparam int FRC_POS   = 28;

  typedef enum logic [3:0] {
    RA_CTRL0 = 4'd0,  RA_CTRL1 = 4'd1,
    RA_ACC0  = 4'd2,  RA_ACC1  = 4'd3,
    RA_BASE0 = 4'd4,  RA_BASE1 = 4'd5,  RA_BASE2 = 4'd6,
    RA_PAIR  = 4'd7,
    RA_ADD0  = 4'd8,  RA_ADD1  = 4'd9,
    RA_PEEK0 = 4'd10, RA_PEEK1 = 4'd11, RA_PEEKF = 4'd12,
    RA_POP0  = 4'd13, RA_POP1  = 4'd14, RA_POPF  = 4'd15
  } regAddr_e;

  typedef struct packed {
    logic [1:0] wrCtrl;
    logic [1:0] wrAcc;
    logic [2:0] wrBase;
    logic       wrPair;
    logic [1:0] wrAdd;
    logic       pop;
    logic       rdValid;
  } strobe_t;

endpackage

// File: rtl/interp_lane.sv
module interp_lane #(
  parameter int DW = 32,
  parameter int SW = $clog2(DW)
) (
  input  logic [DW-1:0] srcVal,
  input  logic [SW-1:0] shiftAmt,
  input  logic [SW-1:0] lsbPos,
  input  logic [SW-1:0] msbPos,
  input  logic          sgnEn,
  output logic [DW-1:0] fieldVal,
  output logic          ovfFlag
);
  localparam logic [SW-1:0] TOP = SW'(DW - 1);

  logic [DW-1:0] shifted;
  logic [DW-1:0] hiMask;
  logic [DW-1:0] loMask;
  logic [DW-1:0] fieldMask;
  logic [DW-1:0] masked;

  always_comb begin
    shifted   = srcVal >> shiftAmt;
    hiMask    = {DW{1'b1}} >> (TOP - msbPos);
    loMask    = {DW{1'b1}} << lsbPos;
    fieldMask = (msbPos >= lsbPos) ? (hiMask & loMask) : '0;
    masked    = shifted & fieldMask;
    fieldVal  = (sgnEn && masked[msbPos]) ? (masked | ~hiMask) : masked;
    ovfFlag   = |(shifted & ~hiMask);
  end

endmodule

// File: rtl/interp_ctrl.sv
module interp_ctrl
  import interp_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     wrEn,
  input  logic     rdEn,
  input  regAddr_e addr,
  output strobe_t  stb
);

  always_comb begin
    stb = '0;
    if (wrEn) begin
      unique case (addr)
        RA_CTRL0: stb.wrCtrl[0] = 1'b1;
        RA_CTRL1: stb.wrCtrl[1] = 1'b1;
        RA_ACC0:  stb.wrAcc[0]  = 1'b1;
        RA_ACC1:  stb.wrAcc[1]  = 1'b1;
        RA_BASE0: stb.wrBase[0] = 1'b1;
        RA_BASE1: stb.wrBase[1] = 1'b1;
        RA_BASE2: stb.wrBase[2] = 1'b1;
        RA_PAIR:  stb.wrPair    = 1'b1;
        RA_ADD0:  stb.wrAdd[0]  = 1'b1;
        RA_ADD1:  stb.wrAdd[1]  = 1'b1;
        default:  ;
      endcase
    end else if (rdEn) begin
      stb.rdValid = 1'b1;
      stb.pop = (addr == RA_POP0) || (addr == RA_POP1) || (addr == RA_POPF);
    end
  end

  // R14
  wr_strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrCtrl, stb.wrAcc, stb.wrBase, stb.wrPair, stb.wrAdd, stb.pop}));

  // R14
  pop_needs_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop |-> (rdEn && !wrEn));

endmodule

// File: rtl/interp_dp.sv
module interp_dp
  import interp_pkg::*;
#(
  parameter int DW   = 32,
  parameter int MODE = MODE_BLEND
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  regAddr_e      rdSel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int  SW        = $clog2(DW);
  localparam int  HALF      = DW / 2;
  localparam bit  HAS_BLEND = (MODE == MODE_BLEND);
  localparam bit  HAS_CLAMP = (MODE == MODE_CLAMP);
  localparam logic [DW-1:0] CTRL_BASE = DW'((1 << (FRC_LO + 2)) - 1);
  localparam logic [DW-1:0] CTRL0_KEEP = CTRL_BASE
      | (HAS_BLEND ? DW'(1) << BIT_BLEND : '0)
      | (HAS_CLAMP ? DW'(1) << BIT_CLAMP : '0);

  logic [DW-1:0] acc     [2];
  logic [DW-1:0] base    [3];
  logic [DW-1:0] ctrlReg [2];

  logic [DW-1:0] laneSrc  [2];
  logic [DW-1:0] laneVal  [2];
  logic [DW-1:0] rawOrVal [2];
  logic [DW-1:0] laneRes  [2];
  logic [1:0]    laneOvf;
  logic [DW-1:0] fullRes;

  // lane front ends: input select + shift/mask/extend
  for (genvar i = 0; i < 2; i++) begin : g_lane
    assign laneSrc[i]  = ctrlReg[i][BIT_XIN] ? acc[1-i] : acc[i];
    assign rawOrVal[i] = ctrlReg[i][BIT_RAW] ? laneSrc[i] : laneVal[i];

    interp_lane #(.DW(DW), .SW(SW)) lane_i (
      .srcVal   (laneSrc[i]),
      .shiftAmt (ctrlReg[i][SH_LO  +: SW]),
      .lsbPos   (ctrlReg[i][LSB_LO +: SW]),
      .msbPos   (ctrlReg[i][MSB_LO +: SW]),
      .sgnEn    (ctrlReg[i][BIT_SGN]),
      .fieldVal (laneVal[i]),
      .ovfFlag  (laneOvf[i])
    );
  end

  // blend interpolation arithmetic
  logic          blendOn;
  logic [DW:0]   blendDiff;
  logic [DW+7:0] blendProd;
  logic [DW-1:0] blendVal;

  always_comb begin
    blendOn   = HAS_BLEND && ctrlReg[0][BIT_BLEND];
    blendDiff = ctrlReg[1][BIT_SGN]
              ? ({base[1][DW-1], base[1]} - {base[0][DW-1], base[0]})
              : ({1'b0, base[1]} - {1'b0, base[0]});
    blendProd = {{7{blendDiff[DW]}}, blendDiff} * {{DW{1'b0}}, laneVal[1][7:0]};
    blendVal  = base[0] + DW'(blendProd >> 8);
  end

  // clamp comparison
  logic clampOn;
  logic clampLow;
  logic clampHigh;

  always_comb begin
    clampOn = HAS_CLAMP && ctrlReg[0][BIT_CLAMP];
    if (ctrlReg[0][BIT_SGN]) begin
      clampLow  = $signed(rawOrVal[0]) < $signed(base[0]);
      clampHigh = $signed(rawOrVal[0]) > $signed(base[1]);
    end else begin
      clampLow  = rawOrVal[0] < base[0];
      clampHigh = rawOrVal[0] > base[1];
    end
  end

  // result selection
  always_comb begin
    laneRes[0] = rawOrVal[0] + base[0];
    laneRes[1] = rawOrVal[1] + base[1];
    fullRes    = base[2] + laneVal[0] + laneVal[1];
    if (blendOn) begin
      laneRes[0] = rawOrVal[0];
      laneRes[1] = blendVal;
      fullRes    = base[2] + laneVal[0];
    end
    if (clampOn) begin
      laneRes[0] = clampLow ? base[0] : (clampHigh ? base[1] : rawOrVal[0]);
    end
  end

  // state update
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 2; i++) begin
        acc[i]     <= '0;
        ctrlReg[i] <= '0;
      end
      for (int j = 0; j < 3; j++) base[j] <= '0;
    end else begin
      if (stb.pop) begin
        acc[0] <= ctrlReg[0][BIT_XRES] ? laneRes[1] : laneRes[0];
        acc[1] <= ctrlReg[1][BIT_XRES] ? laneRes[0] : laneRes[1];
      end
      for (int i = 0; i < 2; i++) begin
        if (stb.wrAcc[i]) acc[i] <= wdata;
        if (stb.wrAdd[i]) acc[i] <= acc[i] + wdata;
      end
      if (stb.wrCtrl[0]) ctrlReg[0] <= wdata & CTRL0_KEEP;
      if (stb.wrCtrl[1]) ctrlReg[1] <= wdata & CTRL_BASE;
      for (int j = 0; j < 3; j++) begin
        if (stb.wrBase[j]) base[j] <= wdata;
      end
      if (stb.wrPair) begin
        base[0] <= {{HALF{ctrlReg[0][BIT_SGN] & wdata[HALF-1]}}, wdata[HALF-1:0]};
        base[1] <= {{HALF{ctrlReg[1][BIT_SGN] & wdata[DW-1]}},   wdata[DW-1:HALF]};
      end
    end
  end

  // read path
  logic [DW-1:0] frc0;
  logic [DW-1:0] frc1;
  logic [DW-1:0] rdMux;

  always_comb begin
    frc0 = DW'(ctrlReg[0][FRC_LO +: 2]) << FRC_POS;
    frc1 = DW'(ctrlReg[1][FRC_LO +: 2]) << FRC_POS;
    unique case (rdSel)
      RA_CTRL0: rdMux = ctrlReg[0]
                      | (DW'(laneOvf[0]) << BIT_OVF0)
                      | (DW'(laneOvf[1]) << BIT_OVF1)
                      | (DW'(|laneOvf)   << BIT_OVFA);
      RA_CTRL1: rdMux = ctrlReg[1];
      RA_ACC0:  rdMux = acc[0];
      RA_ACC1:  rdMux = acc[1];
      RA_BASE0: rdMux = base[0];
      RA_BASE1: rdMux = base[1];
      RA_BASE2: rdMux = base[2];
      RA_PAIR:  rdMux = '0;
      RA_ADD0:  rdMux = laneVal[0];
      RA_ADD1:  rdMux = laneVal[1];
      RA_PEEK0, RA_POP0: rdMux = laneRes[0] | frc0;
      RA_PEEK1, RA_POP1: rdMux = laneRes[1] | frc1;
      default:  rdMux = fullRes;
    endcase
    rdata = stb.rdValid ? rdMux : '0;
  end

  // R6
  peek_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdValid && !stb.pop) |=> ($stable(acc[0]) && $stable(acc[1])));

  // R6
  pop_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop |=> (acc[0] == $past(ctrlReg[0][BIT_XRES] ? laneRes[1] : laneRes[0])
              && acc[1] == $past(ctrlReg[1][BIT_XRES] ? laneRes[0] : laneRes[1])));

  // R8
  add_acc_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrAdd[0] |=> (acc[0] == $past(acc[0] + wdata)));

  // R2
  zero_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[0][MSB_LO +: SW] < ctrlReg[0][LSB_LO +: SW]) |-> (laneVal[0] == '0));

  if (HAS_CLAMP) begin : g_clamp_chk
    // R11
    clamp_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      (clampOn && !ctrlReg[0][BIT_SGN] && base[0] <= base[1])
        |-> (laneRes[0] >= base[0] && laneRes[0] <= base[1]));
  end

endmodule

// File: rtl/interp_unit.sv
module interp_unit
  import interp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MODE   = MODE_BLEND
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [3:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata
);
  strobe_t  stb;
  regAddr_e addrSel;

  assign addrSel = regAddr_e'(busAddr);

  interp_ctrl ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .wrEn (busWrEn),
    .rdEn (busRdEn),
    .addr (addrSel),
    .stb  (stb)
  );

  interp_dp #(.DW(DATA_W), .MODE(MODE)) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .rdSel (addrSel),
    .wdata (busWdata),
    .rdata (busRdata)
  );

endmodule

// File: tb/interp_unit_tb_top.sv
module interp_unit_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic        wrEn  [2];
  logic        rdEn  [2];
  logic [3:0]  addr  [2];
  logic [31:0] wdata [2];
  logic [31:0] rdata [2];

  interp_unit #(.DATA_W(32), .MODE(1)) dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(wrEn[0]), .busRdEn(rdEn[0]),
    .busAddr(addr[0]), .busWdata(wdata[0]), .busRdata(rdata[0]));

  interp_unit #(.DATA_W(32), .MODE(2)) dut_clamp_i (
    .clk(clk), .rstN(rstN), .busWrEn(wrEn[1]), .busRdEn(rdEn[1]),
    .busAddr(addr[1]), .busWdata(wdata[1]), .busRdata(rdata[1]));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model state: [instance][lane]
  logic [31:0] mAcc  [2][2];
  logic [31:0] mCtrl [2][2];
  logic [31:0] mBase [2][3];

  function automatic logic [31:0] mSrc(int u, int l);
    return mCtrl[u][l][16] ? mAcc[u][1-l] : mAcc[u][l];
  endfunction

  function automatic logic [31:0] mShifted(int u, int l);
    return mSrc(u, l) >> mCtrl[u][l][4:0];
  endfunction

  function automatic logic [31:0] mField(int u, int l);
    logic [31:0] sh = mShifted(u, l);
    int lo = int'(mCtrl[u][l][9:5]);
    int hi = int'(mCtrl[u][l][14:10]);
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++) if (b >= lo && b <= hi) r[b] = sh[b];
    if (mCtrl[u][l][15] && hi >= lo && sh[hi])
      for (int b = 0; b < 32; b++) if (b > hi) r[b] = 1'b1;
    return r;
  endfunction

  function automatic logic mOvf(int u, int l);
    logic [31:0] sh = mShifted(u, l);
    int hi = int'(mCtrl[u][l][14:10]);
    logic any = 1'b0;
    for (int b = 0; b < 32; b++) if (b > hi && sh[b]) any = 1'b1;
    return any;
  endfunction

  function automatic logic [31:0] mLane(int u, int l);
    logic [31:0] v = mCtrl[u][l][18] ? mSrc(u, l) : mField(u, l);
    if (mCtrl[u][0][21]) begin
      if (l == 0) return v;
      begin
        longint b0, b1, a, t;
        a  = longint'(mField(u, 1) & 32'hFF);
        b0 = mCtrl[u][1][15] ? longint'($signed(mBase[u][0])) : longint'(mBase[u][0]);
        b1 = mCtrl[u][1][15] ? longint'($signed(mBase[u][1])) : longint'(mBase[u][1]);
        t  = (b0 * (256 - a) + b1 * a) >>> 8;
        return t[31:0];
      end
    end
    if (mCtrl[u][0][22] && l == 0) begin
      logic lo, hi;
      if (mCtrl[u][0][15]) begin
        lo = $signed(v) < $signed(mBase[u][0]);
        hi = $signed(v) > $signed(mBase[u][1]);
      end else begin
        lo = v < mBase[u][0];
        hi = v > mBase[u][1];
      end
      return lo ? mBase[u][0] : (hi ? mBase[u][1] : v);
    end
    return v + mBase[u][l];
  endfunction

  function automatic logic [31:0] mFull(int u);
    if (mCtrl[u][0][21]) return mBase[u][2] + mField(u, 0);
    return mBase[u][2] + mField(u, 0) + mField(u, 1);
  endfunction

  function automatic logic [31:0] mRead(int u, int a);
    logic [31:0] f0 = {2'b0, mCtrl[u][0][20:19], 28'b0};
    logic [31:0] f1 = {2'b0, mCtrl[u][1][20:19], 28'b0};
    case (a)
      0: return mCtrl[u][0] | (32'(mOvf(u, 0)) << 23) | (32'(mOvf(u, 1)) << 24)
              | (32'(mOvf(u, 0) | mOvf(u, 1)) << 25);
      1: return mCtrl[u][1];
      2: return mAcc[u][0];
      3: return mAcc[u][1];
      4: return mBase[u][0];
      5: return mBase[u][1];
      6: return mBase[u][2];
      8: return mField(u, 0);
      9: return mField(u, 1);
      10, 13: return mLane(u, 0) | f0;
      11, 14: return mLane(u, 1) | f1;
      12, 15: return mFull(u);
      default: return 32'h0;
    endcase
  endfunction

  task automatic mWrite(int u, int a, logic [31:0] d);
    case (a)
      0: mCtrl[u][0] = d & (32'h1F_FFFF | (u == 0 ? 32'h20_0000 : 32'h40_0000));
      1: mCtrl[u][1] = d & 32'h1F_FFFF;
      2: mAcc[u][0] = d;
      3: mAcc[u][1] = d;
      4: mBase[u][0] = d;
      5: mBase[u][1] = d;
      6: mBase[u][2] = d;
      7: begin
        mBase[u][0] = {{16{mCtrl[u][0][15] & d[15]}}, d[15:0]};
        mBase[u][1] = {{16{mCtrl[u][1][15] & d[31]}}, d[31:16]};
      end
      8: mAcc[u][0] = mAcc[u][0] + d;
      9: mAcc[u][1] = mAcc[u][1] + d;
      default: ;
    endcase
  endtask

  task automatic mPop(int u);
    logic [31:0] r0 = mLane(u, 0);
    logic [31:0] r1 = mLane(u, 1);
    mAcc[u][0] = mCtrl[u][0][17] ? r1 : r0;
    mAcc[u][1] = mCtrl[u][1][17] ? r0 : r1;
  endtask

  task automatic idleBus();
    for (int u = 0; u < 2; u++) begin
      wrEn[u] = 1'b0; rdEn[u] = 1'b0; addr[u] = '0; wdata[u] = '0;
    end
  endtask

  task automatic busWr(int u, int a, logic [31:0] d);
    @(negedge clk);
    idleBus();
    wrEn[u] = 1'b1; addr[u] = 4'(a); wdata[u] = d;
    mWrite(u, a, d);
  endtask

  task automatic compare(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busRd(int u, int a, string tag);
    logic [31:0] exp;
    @(negedge clk);
    idleBus();
    rdEn[u] = 1'b1; addr[u] = 4'(a);
    exp = mRead(u, a);
    #2;
    compare($sformatf("%s inst%0d addr%0d", tag, u, a), rdata[u], exp);
    if (a >= 13) mPop(u);
  endtask

  function automatic logic [31:0] mkCtrl(int sh, int lo, int hi, logic [31:0] flags);
    return 32'(sh) | (32'(lo) << 5) | (32'(hi) << 10) | flags;
  endfunction

  function automatic logic [31:0] rndCtrl();
    int lo = int'($urandom % 32);
    int hi = lo + int'($urandom % (32 - lo));
    int sh = int'($urandom % 32);
    if ($urandom % 8 == 0) begin int t = lo; lo = hi; hi = t; end
    return mkCtrl(sh, lo, hi, $urandom & 32'hFFFF_8000);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int u = 0; u < 2; u++) begin
      for (int l = 0; l < 2; l++) begin mAcc[u][l] = '0; mCtrl[u][l] = '0; end
      for (int j = 0; j < 3; j++) mBase[u][j] = '0;
    end
    idleBus();
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int u = 0; u < 2; u++)
      for (int a = 0; a < 13; a++) busRd(u, a, "R1");

    // R2 shift and field
    busWr(0, 0, mkCtrl(4, 0, 7, 0));
    busWr(0, 2, 32'h0000_1234);
    busRd(0, 10, "R2");
    compare("R2 direct", mField(0, 0), 32'h23);
    busWr(0, 0, mkCtrl(0, 8, 3, 0));
    busRd(0, 8, "R2");

    // R3 sign extension
    busWr(0, 0, mkCtrl(0, 0, 7, 32'h8000));
    busWr(0, 2, 32'h0000_0080);
    busRd(0, 8, "R3");
    compare("R3 direct", mField(0, 0), 32'hFFFF_FF80);

    // R4 base add, raw bypass, full result
    busWr(0, 4, 32'd100);
    busWr(0, 6, 32'd7);
    busWr(0, 3, 32'h0000_0F0F);
    busWr(0, 1, mkCtrl(4, 0, 3, 0));
    busRd(0, 10, "R4");
    busWr(0, 0, mkCtrl(0, 0, 7, 32'h4_0000));
    busRd(0, 10, "R4");
    busRd(0, 12, "R4");

    // R5 cross input
    busWr(0, 1, mkCtrl(0, 0, 15, 32'h1_0000));
    busRd(0, 11, "R5");
    busRd(0, 9, "R5");

    // R6 peek vs pop with cross result
    busRd(0, 10, "R6");
    busRd(0, 2, "R6");
    busRd(0, 13, "R6");
    busRd(0, 2, "R6");
    busWr(0, 1, mkCtrl(0, 0, 31, 32'h2_0000));
    busRd(0, 15, "R6");
    busRd(0, 3, "R6");

    // R7 forced upper bits
    busWr(0, 0, mkCtrl(0, 0, 31, 32'h18_0000));
    busWr(0, 2, 32'h0000_0010);
    busRd(0, 13, "R7");
    busRd(0, 2, "R7");

    // R8 accumulator add
    busWr(0, 8, 32'd5);
    busRd(0, 2, "R8");
    busRd(0, 8, "R8");

    // R9 base pair
    busWr(0, 0, mkCtrl(0, 0, 31, 32'h8000));
    busWr(0, 1, mkCtrl(0, 0, 31, 0));
    busWr(0, 7, 32'h8001_F00F);
    busRd(0, 4, "R9");
    busRd(0, 5, "R9");

    // R10 blend
    busWr(0, 4, 32'd1000);
    busWr(0, 5, 32'd2000);
    busWr(0, 1, mkCtrl(0, 0, 7, 0));
    busWr(0, 3, 32'd64);
    busWr(0, 0, mkCtrl(0, 0, 7, 32'h20_0000));
    busRd(0, 11, "R10");
    compare("R10 direct", mLane(0, 1), 32'd1250);
    busRd(0, 10, "R10");
    busRd(0, 12, "R10");
    busWr(0, 1, mkCtrl(0, 0, 7, 32'h8000));
    busWr(0, 4, 32'hFFFF_FF00);
    busRd(0, 11, "R10");

    // R11 clamp
    busWr(1, 0, mkCtrl(0, 0, 31, 32'h40_0000));
    busWr(1, 4, 32'd10);
    busWr(1, 5, 32'd20);
    busWr(1, 2, 32'd5);
    busRd(1, 10, "R11");
    busWr(1, 2, 32'd15);
    busRd(1, 10, "R11");
    busWr(1, 2, 32'd30);
    busRd(1, 10, "R11");
    busWr(1, 0, mkCtrl(0, 0, 31, 32'h40_8000));
    busWr(1, 4, 32'hFFFF_FFF6);
    busWr(1, 2, 32'hFFFF_FFF0);
    busRd(1, 10, "R11");

    // R12 overflow flags
    busWr(0, 0, mkCtrl(0, 0, 3, 0));
    busWr(0, 2, 32'h0000_0100);
    busRd(0, 0, "R12");
    busWr(0, 1, mkCtrl(0, 0, 3, 0));
    busWr(0, 3, 32'h0000_0010);
    busRd(0, 0, "R12");

    // R13 mode bits per instance
    busWr(0, 0, 32'hFFFF_FFFF);
    busRd(0, 0, "R13");
    busWr(1, 0, 32'hFFFF_FFFF);
    busRd(1, 0, "R13");
    busWr(1, 1, 32'hFFFF_FFFF);
    busRd(1, 1, "R13");

    // R14 read-back and write priority over read
    busWr(1, 6, 32'hCAFE_0001);
    busRd(1, 6, "R14");
    @(negedge clk);
    idleBus();
    wrEn[1] = 1'b1; rdEn[1] = 1'b1; addr[1] = 4'd3; wdata[1] = 32'h0000_0ABC;
    mWrite(1, 3, 32'h0000_0ABC);
    #2;
    compare("R14 collide rdata", rdata[1], 32'h0);
    busRd(1, 3, "R14");

    // seeded random traffic on both instances
    for (int n = 0; n < 4000; n++) begin
      int u = int'($urandom % 2);
      int a = int'($urandom % 16);
      if ($urandom % 2 == 0) begin
        logic [31:0] d = (a < 2) ? rndCtrl() : $urandom;
        busWr(u, a, d);
      end else begin
        busRd(u, a, "random");
      end
    end

    @(negedge clk);
    idleBus();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule